// File: doc/BRIEF.md
# Write Page Collector with Address Counter

This block sits between the byte-level receiver of a two-wire serial memory slave and the array writer behind it. It holds the current word address and gathers the data bytes of one write transaction into a sixteen-slot page latch. The bytes wait there until a commit hands the whole page to the array in one operation. During sequential reads it steps the same address forward.

Writes and reads advance the address in different ways. A written byte moves only the slot index, which is the low four address bits, and that index wraps inside the page. A read advance moves the full eleven-bit address and wraps from the top of the address space to zero. Between transactions the address stays at one past the last byte accessed.

The incoming byte stream uses valid/ready. A byte is taken on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` drops from the cycle after a commit request until that commit ends. The commit side is a valid/ready stream toward the array writer. `cm_valid` stays high, with the page base, flags and data held, until the writer raises `cm_ready`. Address loads and read advances are plain strobes.

Top module: `pbuf_page_collector`

## Requirements
- R1: After reset, `cur_addr` is 0, `page_flags` is 0, `cm_valid` is 0 and `wr_ready` is 1.
- R2: An accepted `addr_load` sets `cur_addr` to `addr_in` on the next edge. It also sets `page_base` to `addr_in[10:4]` and clears every page flag.
- R3: An accepted byte is stored in slot `cur_addr[3:0]`, which is `page_data[slot*8 +: 8]`. The same byte sets `page_flags[slot]`.
- R4: After an accepted byte, `cur_addr[3:0]` goes up by one modulo 16 and `cur_addr[10:4]` is unchanged.
- R5: With more than sixteen bytes in one transaction, the slot index wraps and later bytes overwrite earlier ones. The flags saturate at all ones.
- R6: An accepted `rd_adv` adds one to the whole 11-bit `cur_addr`, so 2047 is followed by 0.
- R7: In a cycle with no accepted load, byte or read advance, `cur_addr` keeps its value.
- R8: A `commit_req` while at least one flag is set raises `cm_valid` on the next edge. `cm_valid`, `page_base`, `page_flags` and `page_data` then hold until the cycle with `cm_ready` high. After that cycle `cm_valid` is 0 and all flags are 0.
- R9: A `commit_req` with no flag set never raises `cm_valid`. `wr_ready` is low for exactly one cycle and then returns to 1.
- R10: From the cycle after a commit request until the commit ends, `wr_ready` is 0 and the block ignores `wr_valid`, `addr_load` and `rd_adv`. Address, flags and data do not change.
- R11: When strobes coincide, `addr_load` wins over a byte and over `rd_adv`, and a byte wins over `rd_adv`. Each losing strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Load strobe for the word address |
| addr_in | input | 11 | Word address to load |
| wr_valid | input | 1 | Write byte valid |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Byte can be taken (no commit in progress) |
| rd_adv | input | 1 | Read advance strobe |
| commit_req | input | 1 | Request to commit the collected page |
| cm_valid | output | 1 | Page is offered to the array writer |
| cm_ready | input | 1 | Array writer takes the page |
| cur_addr | output | 11 | Current word address |
| page_base | output | 7 | Upper address bits of the collected page |
| page_flags | output | 16 | Per-slot valid flags |
| page_data | output | 128 | Slot data, slot i in bits [8i+7:8i] |

## Verification
A wrong slot index shows on the next edge in two ways: a byte lands in the wrong lane of `page_data`, and the wrong bit of `page_flags` rises. A counter that carries past the page, or fails to carry on reads, shows in the upper bits of `cur_addr` within one cycle. This is probed at the page wrap and at the 2047-to-0 boundary. A commit handshake that does not hold its state shows as `cm_valid` dropping, or flags clearing, before `cm_ready`. A zero-byte commit that sticks shows as `wr_ready` staying low past the single expected cycle.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  localparam int PB_ADDR_W = 11;
  localparam int PB_SLOT_W = 4;
  localparam int PB_DATA_W = 8;

  typedef enum logic {
    CM_IDLE = 1'b0,
    CM_BUSY = 1'b1
  } cm_state_e;
endpackage

// File: rtl/pbuf_addr_ctr.sv
module pbuf_addr_ctr #(
  parameter int ADDR_W = 11,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              wr_step,
  input  logic              rd_step,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam logic [SLOT_W-1:0] SLOT_ONE = SLOT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [SLOT_W-1:0] slot_next;
  assign slot_next = cur_addr[SLOT_W-1:0] + SLOT_ONE;

  always_ff @(posedge clk) begin
    if (!rst_n)       cur_addr <= '0;
    else if (load)    cur_addr <= load_addr;
    else if (wr_step) cur_addr <= {cur_addr[ADDR_W-1:SLOT_W], slot_next};
    else if (rd_step) cur_addr <= cur_addr + ADDR_ONE;
  end

  // R4: a byte step moves only the slot bits, the page bits stay
  assert_wr_page_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_step && !load) |=> (cur_addr[ADDR_W-1:SLOT_W] == $past(cur_addr[ADDR_W-1:SLOT_W])));

  // R6: a read step advances the full address
  assert_rd_full_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_step && !load && !wr_step) |=> (cur_addr == $past(cur_addr) + ADDR_ONE));

  // R7: no strobe, no movement
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !wr_step && !rd_step) |=> $stable(cur_addr));
endmodule

// File: rtl/pbuf_page_latch.sv
module pbuf_page_latch #(
  parameter int SLOT_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr_all,
  input  logic                            wr_en,
  input  logic [SLOT_W-1:0]               wr_slot,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [(1<<SLOT_W)-1:0]          flags,
  output logic [(1<<SLOT_W)*DATA_W-1:0]   data
);
  localparam int SLOTS = 1 << SLOT_W;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == SLOT_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n)       flags[s] <= 1'b0;
      else if (clr_all) flags[s] <= 1'b0;
      else if (hit)     flags[s] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)   data[s*DATA_W +: DATA_W] <= '0;
      else if (hit) data[s*DATA_W +: DATA_W] <= wr_data;
    end
  end

  // R8: a clear leaves no flag behind
  assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (flags == '0));

  // R10: without a write or a clear the page content is frozen
  assert_page_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr_all) |=> ($stable(flags) && $stable(data)));

  // R3: a written slot is flagged afterwards
  assert_slot_flagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_all) |=> ($countones(flags) >= 1));
endmodule

// File: rtl/pbuf_commit_ctl.sv
module pbuf_commit_ctl
  import pbuf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic commit_req,
  input  logic any_valid,
  input  logic cm_ready,
  output logic busy,
  output logic cm_valid,
  output logic done
);
  cm_state_e state;

  assign busy     = (state == CM_BUSY);
  assign cm_valid = busy && any_valid;
  assign done     = cm_valid && cm_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= CM_IDLE;
    else begin
      case (state)
        CM_IDLE: if (commit_req) state <= CM_BUSY;
        CM_BUSY: if (!any_valid || cm_ready) state <= CM_IDLE;
        default: state <= CM_IDLE;
      endcase
    end
  end

  // R8: an offered page stays offered until taken
  assert_cm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_ready) |=> cm_valid);

  // R9: an empty commit ends after one cycle
  assert_empty_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !any_valid) |=> !busy);
endmodule

// File: rtl/pbuf_page_collector.sv
module pbuf_page_collector
  import pbuf_pkg::*;
#(
  parameter int ADDR_W = PB_ADDR_W,
  parameter int SLOT_W = PB_SLOT_W,
  parameter int DATA_W = PB_DATA_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          addr_load,
  input  logic [ADDR_W-1:0]             addr_in,
  input  logic                          wr_valid,
  input  logic [DATA_W-1:0]             wr_data,
  output logic                          wr_ready,
  input  logic                          rd_adv,
  input  logic                          commit_req,
  output logic                          cm_valid,
  input  logic                          cm_ready,
  output logic [ADDR_W-1:0]             cur_addr,
  output logic [ADDR_W-SLOT_W-1:0]      page_base,
  output logic [(1<<SLOT_W)-1:0]        page_flags,
  output logic [(1<<SLOT_W)*DATA_W-1:0] page_data
);
  localparam int BASE_W = ADDR_W - SLOT_W;

  logic busy, done, any_valid;
  logic load_go, wr_go, rd_go;

  assign any_valid = |page_flags;
  assign wr_ready  = !busy;
  assign load_go   = addr_load && !busy;
  assign wr_go     = wr_valid && wr_ready && !load_go;
  assign rd_go     = rd_adv && !busy && !load_go && !wr_go;

  pbuf_addr_ctr #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load_go), .load_addr(addr_in),
    .wr_step(wr_go), .rd_step(rd_go), .cur_addr(cur_addr)
  );

  pbuf_page_latch #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .clr_all(load_go || done), .wr_en(wr_go),
    .wr_slot(cur_addr[SLOT_W-1:0]), .wr_data(wr_data),
    .flags(page_flags), .data(page_data)
  );

  pbuf_commit_ctl u_cm (
    .clk(clk), .rst_n(rst_n), .commit_req(commit_req), .any_valid(any_valid),
    .cm_ready(cm_ready), .busy(busy), .cm_valid(cm_valid), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                  page_base <= '0;
    else if (load_go)            page_base <= addr_in[ADDR_W-1:SLOT_W];
    else if (wr_go && !any_valid) page_base <= cur_addr[ADDR_W-1:SLOT_W];
  end

  // R2: a load takes effect on the next edge
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> (cur_addr == $past(addr_in) && page_flags == '0 &&
                 page_base == $past(addr_in[ADDR_W-1:SLOT_W])));

  // R10: while a commit runs nothing moves the address
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> $stable(cur_addr));

  // R8: the offered page base does not move while waiting
  assert_base_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_ready) |=> $stable(page_base));

  logic [BASE_W-1:0] unused_base_w;
  assign unused_base_w = '0;
endmodule

// File: tb/test_pbuf_page_collector.sv
module test_pbuf_page_collector;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         addr_load = 1'b0;
  logic [10:0]  addr_in = '0;
  logic         wr_valid = 1'b0;
  logic [7:0]   wr_data = '0;
  logic         wr_ready;
  logic         rd_adv = 1'b0;
  logic         commit_req = 1'b0;
  logic         cm_valid;
  logic         cm_ready = 1'b0;
  logic [10:0]  cur_addr;
  logic [6:0]   page_base;
  logic [15:0]  page_flags;
  logic [127:0] page_data;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pbuf_page_collector i_pbuf_page_collector (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_adv(rd_adv), .commit_req(commit_req), .cm_valid(cm_valid),
    .cm_ready(cm_ready), .cur_addr(cur_addr), .page_base(page_base),
    .page_flags(page_flags), .page_data(page_data)
  );

  // op codes: 0 idle, 1 load, 2 byte, 3 read advance
  localparam int NV = 14;
  localparam logic [1:0]  V_OP  [NV] = '{1, 3, 3, 3, 0, 1, 2, 2, 2, 0, 3, 1, 2, 3};
  localparam logic [10:0] V_ARG [NV] = '{11'h7FD, 0, 0, 0, 0, 11'h12E, 11'h55, 11'h66,
                                         11'h77, 0, 0, 11'h3FF, 11'h11, 0};
  localparam logic [10:0] V_EXP [NV] = '{11'h7FD, 11'h7FE, 11'h7FF, 11'h000, 11'h000,
                                         11'h12E, 11'h12F, 11'h120, 11'h121, 11'h121,
                                         11'h122, 11'h3FF, 11'h3F0, 11'h3F1};

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive for one edge, sample 2 ns after it, then release strobes
  task automatic cyc(input logic ld, input logic [10:0] a, input logic wv,
                     input logic [7:0] d, input logic rd, input logic cr, input logic ck);
    addr_load = ld; addr_in = a; wr_valid = wv; wr_data = d;
    rd_adv = rd; commit_req = cr; cm_ready = ck;
    @(posedge clk); #2;
    addr_load = 0; wr_valid = 0; rd_adv = 0; commit_req = 0; cm_ready = 0;
  endtask

  initial begin
    logic [127:0] exp_data;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 cur_addr", 128'(cur_addr), 0);
    chk("R1 flags", 128'(page_flags), 0);
    chk("R1 cm_valid", 128'(cm_valid), 0);
    chk("R1 wr_ready", 128'(wr_ready), 1);
    rst_n = 1'b1;
    @(posedge clk); #2;

    for (int i = 0; i < NV; i++) begin
      cyc(V_OP[i] == 1, V_ARG[i], V_OP[i] == 2, V_ARG[i][7:0], V_OP[i] == 3, 0, 0);
      case (V_OP[i])
        2'd1: chk("R2 vector load", 128'(cur_addr), 128'(V_EXP[i]));
        2'd2: chk("R4 vector byte step", 128'(cur_addr), 128'(V_EXP[i]));
        2'd3: chk("R6 vector read step", 128'(cur_addr), 128'(V_EXP[i]));
        default: chk("R7 vector hold", 128'(cur_addr), 128'(V_EXP[i]));
      endcase
    end

    // R2 load clears the flags left by the table and sets the base
    cyc(1, 11'h1F0, 0, 0, 0, 0, 0);
    chk("R2 flags cleared", 128'(page_flags), 0);
    chk("R2 page_base", 128'(page_base), 128'h1F);

    // R3/R5: eighteen bytes, slots 0 and 1 overwritten
    exp_data = '0;
    for (int i = 0; i < 18; i++) begin
      cyc(0, 0, 1, 8'(8'hA0 + i), 0, 0, 0);
      exp_data[(i%16)*8 +: 8] = 8'(8'hA0 + i);
      if (i == 2) chk("R3 flags after three bytes", 128'(page_flags), 128'h0007);
    end
    chk("R5 page_data after wrap", page_data, exp_data);
    chk("R5 flags saturate", 128'(page_flags), 128'hFFFF);
    chk("R4 address after wrap", 128'(cur_addr), 128'h1F2);

    // R8/R10: commit with back-pressure, strobes ignored while busy
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R8 cm_valid raised", 128'(cm_valid), 1);
    chk("R10 wr_ready low", 128'(wr_ready), 0);
    cyc(1, 11'h005, 1, 8'h5A, 1, 0, 0);
    chk("R10 address ignored", 128'(cur_addr), 128'h1F2);
    chk("R10 data ignored", page_data, exp_data);
    chk("R8 cm_valid held", 128'(cm_valid), 1);
    chk("R8 base held", 128'(page_base), 128'h1F);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R8 cm_valid dropped", 128'(cm_valid), 0);
    chk("R8 flags cleared", 128'(page_flags), 0);
    chk("R8 wr_ready back", 128'(wr_ready), 1);

    // R9: empty commit
    cyc(0, 0, 0, 0, 0, 1, 0);
    chk("R9 no cm_valid", 128'(cm_valid), 0);
    chk("R9 wr_ready low one cycle", 128'(wr_ready), 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R9 wr_ready restored", 128'(wr_ready), 1);
    chk("R9 still no cm_valid", 128'(cm_valid), 0);

    // R11: priorities
    cyc(1, 11'h055, 1, 8'hEE, 1, 0, 0);
    chk("R11 load wins", 128'(cur_addr), 128'h055);
    chk("R11 byte dropped on load", 128'(page_flags), 0);
    cyc(0, 0, 1, 8'hC3, 1, 0, 0);
    chk("R11 byte wins over read", 128'(cur_addr), 128'h056);
    chk("R11 byte slot 5 stored", 128'(page_data[5*8 +: 8]), 128'hC3);
    chk("R11 flag slot 5", 128'(page_flags), 128'h0020);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule